// File: doc/BRIEF.md
# Line Miss Request Tracker

This block keeps account of cache-line misses that a first-level data cache has sent toward the next cache level and that have not yet returned. It owns a small pool of slots, ten by default. Each miss from a load, a store or a prefetch takes one slot until the returning line arrives. A request to a line that is already outstanding joins that slot instead of taking a new one.

Fills come back in any order. Each fill carries the slot number it answers. The tracker then frees the slot and passes the line on with its base address.

Demand traffic and software prefetches are handled differently when a request cannot proceed. A load or store that finds every slot taken is held off through its ready signal until a slot frees. A software prefetch never waits. If no slot is free, if its address would fault, or if its translation lookup missed while the drop mode is enabled, the prefetch is consumed and discarded without any error. Every discard is counted.

Top module: `miss_tracker`

## Requirements
- R1: The pool holds ENTRIES slots (10 by default), and `busy_count` never exceeds it. A new allocation takes the lowest-numbered free slot, and that number appears on `acc_tag` in the same cycle.
- R2: A demand request (`req_prefetch`=0) to a line not being tracked, arriving while all slots are busy, sees `req_ready`=0 and is not accepted. Once a fill frees a slot, the held request is accepted in the next cycle.
- R3: A request whose line address (`req_addr` above the low OFF_W bits) matches a busy slot is accepted with `acc_merged`=1 and that slot's tag, and `busy_count` does not change.
- R4: A software prefetch (`req_prefetch`=1) to an untracked line while all slots are busy sees `req_ready`=1, gives `acc_valid`=0, and is discarded.
- R5: A software prefetch with `req_fault`=1 is discarded even when slots are free, and nothing is allocated.
- R6: With DROP_TLB_MISS=1 (the default), a software prefetch with `req_tlb_miss`=1 is discarded.
- R7: A software prefetch that is not discarded allocates a slot exactly like a demand miss and holds it until its fill.
- R8: A fill (`fill_valid`=1) naming a busy slot frees that slot. `busy_count` is one lower after that clock edge. Fills may arrive in any order.
- R9: One cycle after a fill to a busy slot, `out_valid`=1, `out_addr` is the slot's line address with zero low bits, and `out_data` is the fill data. A fill naming an idle slot is ignored.
- R10: `drop_count` increases by exactly one after each clock edge at which a prefetch is discarded.
- R11: Demand requests ignore `req_fault` and `req_tlb_miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | miss request present |
| req_ready | output | 1 | request can be consumed this cycle |
| req_addr | input | ADDR_W | byte address of the miss |
| req_prefetch | input | 1 | 1 = software prefetch, 0 = demand |
| req_tlb_miss | input | 1 | translation lookup missed |
| req_fault | input | 1 | access would fault |
| acc_valid | output | 1 | request took or joined a slot |
| acc_tag | output | TAG_W | slot number used |
| acc_merged | output | 1 | request joined an existing slot |
| fill_valid | input | 1 | fill returning |
| fill_tag | input | TAG_W | slot the fill answers |
| fill_data | input | DATA_W | returned line data |
| out_valid | output | 1 | completed line available |
| out_addr | output | ADDR_W | line base address |
| out_data | output | DATA_W | line data |
| busy_count | output | OCC_W | slots in use |
| drop_count | output | CNT_W | discarded prefetches |

## Verification
Outputs on the request side (`req_ready`, `acc_valid`, `acc_tag`, `acc_merged`) are combinational. The bench drives on the falling edge and reads them 1 ns later, in the same cycle. Slot release, `busy_count` and `drop_count` change at the next rising edge, so the bench reads them at the falling edge after it. Completed lines appear one rising edge after the fill. The driver queues the expected address and data when it sends a fill, and a monitor compares each `out_valid` beat at the following falling edge, flagging any beat for which nothing was queued.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ENTRIES = 10,
  parameter int ADDR_W = 32,
  parameter int OFF_W = 6,
  parameter int DATA_W = 64,
  parameter int CNT_W = 16,
  parameter bit DROP_TLB_MISS = 1'b1,
  localparam int TAG_W = $clog2(ENTRIES),
  localparam int OCC_W = $clog2(ENTRIES + 1),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_prefetch,
  input  logic              req_tlb_miss,
  input  logic              req_fault,
  output logic              acc_valid,
  output logic [TAG_W-1:0]  acc_tag,
  output logic              acc_merged,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [OCC_W-1:0]  busy_count,
  output logic [CNT_W-1:0]  drop_count
);

  logic [ENTRIES-1:0] vld;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [LINE_W-1:0]  req_line;
  logic               hit, free_any, pf_drop, dropped, alloc, fill_hit;
  logic [TAG_W-1:0]   hit_tag, free_tag;

  assign req_line = req_addr[ADDR_W-1:OFF_W];

  always_comb begin
    hit = 1'b0;
    hit_tag = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && line_q[i] == req_line) begin
        hit = 1'b1;
        hit_tag = TAG_W'(i);
      end
    free_any = 1'b0;
    free_tag = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_any = 1'b1;
        free_tag = TAG_W'(i);
      end
  end

  assign pf_drop    = req_prefetch & (req_fault | (DROP_TLB_MISS & req_tlb_miss) | (!hit & !free_any));
  assign req_ready  = req_prefetch | hit | free_any;
  assign dropped    = req_valid & pf_drop;
  assign acc_valid  = req_valid & req_ready & !pf_drop;
  assign acc_merged = hit;
  assign acc_tag    = hit ? hit_tag : free_tag;
  assign alloc      = acc_valid & !hit;
  assign fill_hit   = fill_valid && (int'(fill_tag) < ENTRIES) && vld[fill_tag];
  assign busy_count = OCC_W'($countones(vld));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      drop_count <= '0;
      out_valid <= 1'b0;
    end else begin
      if (fill_hit) vld[fill_tag] <= 1'b0;
      if (alloc) vld[free_tag] <= 1'b1;
      if (dropped) drop_count <= drop_count + 1'b1;
      out_valid <= fill_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) line_q[free_tag] <= req_line;
    if (fill_hit) begin
      out_addr <= {line_q[fill_tag], {OFF_W{1'b0}}};
      out_data <= fill_data;
    end
  end

  a_r1_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(busy_count) <= ENTRIES);
  a_r2_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_prefetch && !req_ready) |-> int'(busy_count) == ENTRIES);
  a_r4_prefetch_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_prefetch) |-> req_ready);
  a_r5_fault_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_prefetch && req_fault) |-> !acc_valid);
  a_r8_fill_frees: assert property (@(posedge clk) disable iff (!rst_n)
    fill_hit |=> !vld[$past(fill_tag)]);
  a_r9_out_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_hit |=> out_valid);
  a_r10_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> drop_count == $past(drop_count) + 1'b1);

endmodule

// File: tb/tb_miss_tracker.sv
module tb_miss_tracker;
  localparam int AW = 32, DW = 64, TW = 4, OW = 4, CW = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_prefetch = 0, req_tlb_miss = 0, req_fault = 0;
  logic [AW-1:0] req_addr = '0;
  logic fill_valid = 0;
  logic [TW-1:0] fill_tag = '0;
  logic [DW-1:0] fill_data = '0;
  logic req_ready, acc_valid, acc_merged, out_valid;
  logic [TW-1:0] acc_tag;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic [OW-1:0] busy_count;
  logic [CW-1:0] drop_count;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [AW+DW-1:0] expq[$];

  always #5 clk = ~clk;

  miss_tracker dut (.*);

  task automatic chk(string rq, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [AW-1:0] a, logic pf, logic tlb, logic flt,
                       logic fv, logic [TW-1:0] ft, logic [DW-1:0] fd, bit push);
    @(negedge clk);
    req_valid = v; req_addr = a; req_prefetch = pf; req_tlb_miss = tlb; req_fault = flt;
    fill_valid = fv; fill_tag = ft; fill_data = fd;
    if (push) expq.push_back({AW'(ft) * 64, fd});
    #1;
  endtask

  task automatic idle();
    drive(0, '0, 0, 0, 0, 0, '0, '0, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) chk("R9 unexpected out_valid", 1, 0);
      else begin
        logic [AW+DW-1:0] e;
        e = expq.pop_front();
        chk("R9 out_addr", out_addr, e[AW+DW-1:DW]);
        chk("R9 out_data", out_data, e[DW-1:0]);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset busy", busy_count, 0);
    chk("R10 reset drop", drop_count, 0);
    chk("R9 reset out_valid", out_valid, 0);
    chk("R1 reset ready", req_ready, 1);

    for (int i = 0; i < 10; i++) begin
      drive(1, AW'(i * 64), 0, 0, 0, 0, '0, '0, 0);
      chk("R1 alloc accept", acc_valid, 1);
      chk("R1 alloc lowest tag", acc_tag, i);
      chk("R3 fresh not merged", acc_merged, 0);
    end
    idle();
    chk("R1 full busy", busy_count, 10);

    drive(1, 'h4000, 0, 0, 0, 1, 4, 64'hD4, 1);
    chk("R2 full stalls ready", req_ready, 0);
    chk("R2 full no accept", acc_valid, 0);
    drive(1, 'h4000, 0, 0, 0, 0, '0, '0, 0);
    chk("R2 resumes after free", acc_valid, 1);
    chk("R2 takes freed tag", acc_tag, 4);

    drive(1, 'hC8, 0, 0, 0, 0, '0, '0, 0);
    chk("R3 merge accept", acc_valid, 1);
    chk("R3 merge flag", acc_merged, 1);
    chk("R3 merge tag", acc_tag, 3);
    idle();
    chk("R3 merge keeps busy", busy_count, 10);

    drive(1, 'h5000, 1, 0, 0, 0, '0, '0, 0);
    chk("R4 prefetch ready when full", req_ready, 1);
    chk("R4 prefetch dropped", acc_valid, 0);
    idle();
    chk("R10 drop count 1", drop_count, 1);
    chk("R4 busy unchanged", busy_count, 10);

    drive(0, '0, 0, 0, 0, 1, 7, 64'hA7, 1);
    drive(0, '0, 0, 0, 0, 1, 2, 64'hA2, 1);
    idle();
    chk("R8 out-of-order frees", busy_count, 8);

    drive(1, 'h1000, 0, 0, 0, 0, '0, '0, 0);
    chk("R1 lowest free after frees", acc_tag, 2);

    drive(1, 'h6000, 1, 0, 1, 0, '0, '0, 0);
    chk("R5 fault prefetch dropped", acc_valid, 0);
    chk("R5 fault prefetch ready", req_ready, 1);
    drive(1, 'h7000, 1, 1, 0, 0, '0, '0, 0);
    chk("R6 tlb miss prefetch dropped", acc_valid, 0);
    idle();
    chk("R10 drop count 3", drop_count, 3);
    chk("R5 nothing allocated", busy_count, 9);

    drive(1, 'h2000, 1, 0, 0, 0, '0, '0, 0);
    chk("R7 prefetch allocates", acc_valid, 1);
    chk("R7 prefetch tag", acc_tag, 7);
    idle();
    chk("R7 prefetch holds slot", busy_count, 10);

    drive(0, '0, 0, 0, 0, 1, 0, 64'hA0, 1);
    drive(1, 'h3000, 0, 1, 1, 0, '0, '0, 0);
    chk("R11 demand ignores flags", acc_valid, 1);
    chk("R11 demand tag", acc_tag, 0);

    drive(0, '0, 0, 0, 0, 1, 5, 64'hA5, 1);
    drive(0, '0, 0, 0, 0, 1, 5, 64'hEE, 0);
    idle();
    chk("R9 idle-slot fill ignored busy", busy_count, 9);
    chk("R10 drop stable", drop_count, 3);
    idle();
    chk("R9 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule